// File: doc/BRIEF.md
# SIR Receive Frame Unwrapper

This block sits behind a slow-infrared UART deframer and turns its raw byte stream into bare packet contents. A begin flag (0xC0) opens a frame, and an end flag (0xC1) closes it. Between the two, escape sequences are undone. Only payload bytes are forwarded, and the trailing 16-bit frame check sequence stays in the forwarded stream for a later stage to verify. When a frame closes, the block emits a separate marker beat that carries the packet's error status.

A 12-bit counter holds the number of bytes forwarded for the current packet. This counter is compared against a programmable maximum length. A frame that overruns the limit stops forwarding and is closed with a length error. A frame that is cut short by a new begin flag is closed with a bad-frame error, and the new flag opens the next frame. An escape byte followed directly by a flag is reported as a physical encoding error. Both flag values are hard-wired and can be read back on a constant output.

Top module: `sirf_unwrap`

## Requirements
- R1: `sir_flags_o` always reads 16'hC1C0: the end flag is in bits [15:8] and the begin flag is in bits [7:0].
- R2: While no frame is open, every input byte other than 0xC0 is dropped. Such a byte produces no output beat and leaves `rx_count_o` unchanged.
- R3: A 0xC0 received outside a frame opens a frame and clears `rx_count_o` to 0. A further 0xC0 that arrives before any other byte of the frame is dropped silently.
- R4: Inside a frame, each accepted payload byte appears on `out_byte_o` with `out_valid_o`=1 and `out_last_o`=0 on the clock edge after its input edge. The bytes keep their input order, and `rx_count_o` rises by one for each forwarded byte.
- R5: Inside a frame, an escape byte 0x7D is dropped. The next non-flag byte is forwarded XORed with 0x20, so a second 0x7D in that position is data (0x5D).
- R6: A 0xC1 inside a frame produces one marker beat (`out_valid_o`=1, `out_last_o`=1, `out_byte_o`=0) that carries the close status. The block then returns to the no-frame state, and `rx_count_o` keeps the final count.
- R7: A 0xC0 that arrives after at least one other byte of an open frame closes that frame with a marker whose status has bit 0x04 (bad frame) set. A new frame then opens at once with `rx_count_o`=0.
- R8: A payload byte that arrives when `rx_count_o` equals `max_len_i` is dropped. Every later payload byte of that frame is also dropped, and the closing marker has bit 0x10 (length) set.
- R9: An escape byte that is followed directly by 0xC0 or 0xC1 sets bit 0x40 (phy error) in that frame's closing status.
- R10: `out_status_o` is zero on data beats. On markers only bits 0x40, 0x10 and 0x04 can be set. The CRC bit 0x20 and the overrun bit 0x08 are always 0, and any bit in mask 0x7C means the frame has an error.
- R11: After reset there is no open frame, no output beat and `rx_count_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input byte is present this cycle |
| in_byte_i | input | 8 | Received byte from the deframer |
| max_len_i | input | 12 | Largest number of payload bytes accepted per frame |
| out_valid_o | output | 1 | Output beat present (data or marker) |
| out_byte_o | output | 8 | Unescaped payload byte; zero on markers |
| out_last_o | output | 1 | Beat is an end-of-packet marker |
| out_status_o | output | 8 | Close status on markers |
| rx_count_o | output | 12 | Bytes forwarded in the current or most recent frame |
| sir_flags_o | output | 16 | Hard-wired flag pair readback |

## Verification
The hardest states to reach are the ones where two conditions meet at a frame edge. Examples are an escape byte left pending when a flag arrives, a begin flag that cuts a frame short after it has already hit its length limit, and a limit of zero. Directed sequences put each of these cases together on purpose. A long pseudo-random stream that is heavy in 0xC0, 0xC1 and 0x7D, run with a small maximum length, then reaches further combinations. A behavioural model checks every output on every cycle.

// File: rtl/sirf_pkg.sv
package sirf_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 12;
    localparam int STAT_W = 8;

    localparam logic [DATA_W-1:0] BOF_BYTE = 8'hC0;
    localparam logic [DATA_W-1:0] EOF_BYTE = 8'hC1;
    localparam logic [DATA_W-1:0] ESC_BYTE = 8'h7D;
    localparam logic [DATA_W-1:0] ESC_XOR  = 8'h20;

    localparam int BIT_PHY    = 6;
    localparam int BIT_CRC    = 5;
    localparam int BIT_LENGTH = 4;
    localparam int BIT_OVER   = 3;
    localparam int BIT_SIRBAD = 2;

    typedef struct packed {
        logic              in_frame;
        logic              body;
        logic              esc;
        logic              len_err;
        logic [CNT_W-1:0]  cnt;
        logic              ov;
        logic              ol;
        logic [DATA_W-1:0] ob;
        logic [STAT_W-1:0] ost;
    } sirf_state_t;
endpackage

// File: rtl/sirf_byte_class.sv
module sirf_byte_class #(
    parameter int                DW  = 8,
    parameter logic [DW-1:0]     BOF = 8'hC0,
    parameter logic [DW-1:0]     EOF = 8'hC1,
    parameter logic [DW-1:0]     ESC = 8'h7D
) (
    input  logic [DW-1:0] byte_i,
    output logic          is_bof_o,
    output logic          is_eof_o,
    output logic          is_esc_o
);
    assign is_bof_o = (byte_i == BOF);
    assign is_eof_o = (byte_i == EOF);
    assign is_esc_o = (byte_i == ESC);
endmodule

// File: rtl/sirf_len_guard.sv
module sirf_len_guard #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] max_i,
    output logic          at_limit_o
);
    assign at_limit_o = (cnt_i >= max_i);
endmodule

// File: rtl/sirf_close_status.sv
module sirf_close_status
    import sirf_pkg::*;
#(
    parameter bit CUT_SHORT = 1'b0
) (
    input  logic              esc_pending_i,
    input  logic              len_err_i,
    output logic [STAT_W-1:0] status_o
);
    always_comb begin
        status_o             = '0;
        status_o[BIT_PHY]    = esc_pending_i;
        status_o[BIT_LENGTH] = len_err_i;
        status_o[BIT_SIRBAD] = CUT_SHORT;
    end
endmodule

// File: rtl/sirf_unwrap.sv
module sirf_unwrap
    import sirf_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_byte_i,
    input  logic [CNT_W-1:0]  max_len_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_byte_o,
    output logic              out_last_o,
    output logic [STAT_W-1:0] out_status_o,
    output logic [CNT_W-1:0]  rx_count_o,
    output logic [2*DATA_W-1:0] sir_flags_o
);
    sirf_state_t st_d, st_q;

    logic is_bof, is_eof, is_esc, at_limit;
    logic [STAT_W-1:0] stat_restart, stat_end;

    sirf_byte_class #(
        .DW (DATA_W), .BOF(BOF_BYTE), .EOF(EOF_BYTE), .ESC(ESC_BYTE)
    ) u_class (
        .byte_i   (in_byte_i),
        .is_bof_o (is_bof),
        .is_eof_o (is_eof),
        .is_esc_o (is_esc)
    );

    sirf_len_guard #(.CW(CNT_W)) u_guard (
        .cnt_i      (st_q.cnt),
        .max_i      (max_len_i),
        .at_limit_o (at_limit)
    );

    sirf_close_status #(.CUT_SHORT(1'b1)) u_stat_restart (
        .esc_pending_i (st_q.esc),
        .len_err_i     (st_q.len_err),
        .status_o      (stat_restart)
    );

    sirf_close_status #(.CUT_SHORT(1'b0)) u_stat_end (
        .esc_pending_i (st_q.esc),
        .len_err_i     (st_q.len_err),
        .status_o      (stat_end)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ov  = 1'b0;
        st_d.ol  = 1'b0;
        st_d.ob  = '0;
        st_d.ost = '0;
        if (in_valid_i) begin
            if (!st_q.in_frame) begin
                if (is_bof) begin
                    st_d.in_frame = 1'b1;
                    st_d.body     = 1'b0;
                    st_d.esc      = 1'b0;
                    st_d.len_err  = 1'b0;
                    st_d.cnt      = '0;
                end
            end else if (is_bof) begin
                if (st_q.body) begin
                    st_d.ov      = 1'b1;
                    st_d.ol      = 1'b1;
                    st_d.ost     = stat_restart;
                    st_d.body    = 1'b0;
                    st_d.esc     = 1'b0;
                    st_d.len_err = 1'b0;
                    st_d.cnt     = '0;
                end
            end else if (is_eof) begin
                st_d.ov       = 1'b1;
                st_d.ol       = 1'b1;
                st_d.ost      = stat_end;
                st_d.in_frame = 1'b0;
                st_d.esc      = 1'b0;
            end else if (!st_q.esc && is_esc) begin
                st_d.esc  = 1'b1;
                st_d.body = 1'b1;
            end else begin
                st_d.esc  = 1'b0;
                st_d.body = 1'b1;
                if (at_limit) begin
                    st_d.len_err = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    st_d.ov  = 1'b1;
                    st_d.ob  = st_q.esc ? (in_byte_i ^ ESC_XOR) : in_byte_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o  = st_q.ov;
    assign out_last_o   = st_q.ol;
    assign out_byte_o   = st_q.ob;
    assign out_status_o = st_q.ost;
    assign rx_count_o   = st_q.cnt;
    assign sir_flags_o  = {EOF_BYTE, BOF_BYTE};

    assert_idle_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(st_q.in_frame) |-> !out_valid_o);

    assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_last_o) |-> (rx_count_o == CNT_W'($past(rx_count_o) + 1'b1)));

    assert_marker_zero_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_last_o |-> (out_valid_o && out_byte_o == '0));

    assert_eof_exits_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_last_o && !out_status_o[BIT_SIRBAD]) |-> !st_q.in_frame);

    assert_restart_fresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_last_o && out_status_o[BIT_SIRBAD]) |-> (st_q.in_frame && rx_count_o == '0));

    assert_within_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_last_o) |-> (rx_count_o <= $past(max_len_i)));

    assert_data_status_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_last_o) |-> (out_status_o == '0));

    assert_no_crc_over_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (!out_status_o[BIT_CRC] && !out_status_o[BIT_OVER]));
endmodule

// File: tb/sirf_unwrap_tb.sv
module sirf_unwrap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [11:0] max_len = 12'd100;
    logic        out_valid, out_last;
    logic [7:0]  out_byte, out_status;
    logic [11:0] rx_count;
    logic [15:0] sir_flags;

    always #5 clk = ~clk;

    sirf_unwrap dut_i (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
        .max_len_i(max_len), .out_valid_o(out_valid), .out_byte_o(out_byte),
        .out_last_o(out_last), .out_status_o(out_status), .rx_count_o(rx_count),
        .sir_flags_o(sir_flags)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string tag = "R11";

    // behavioural reference state
    bit m_in = 0, m_body = 0, m_esc = 0, m_len = 0;
    int m_cnt = 0;
    bit e_v = 0, e_last = 0;
    int e_byte = 0, e_stat = 0;

    task automatic check(string t, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", t, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(tag, "out_valid", int'(out_valid), int'(e_v));
        check(tag, "out_last", int'(out_last), int'(e_last));
        check(tag, "out_byte", int'(out_byte), e_byte);
        check(tag, "out_status", int'(out_status), e_stat);
        check(tag, "rx_count", int'(rx_count), m_cnt);
    endtask

    task automatic model(bit v, int b);
        int data;
        e_v = 0; e_last = 0; e_byte = 0; e_stat = 0;
        if (!v) return;
        if (!m_in) begin
            if (b == 'hC0) begin m_in = 1; m_body = 0; m_esc = 0; m_len = 0; m_cnt = 0; end
        end else if (b == 'hC0) begin
            if (m_body) begin
                e_v = 1; e_last = 1;
                e_stat = 'h04 | (m_esc ? 'h40 : 0) | (m_len ? 'h10 : 0);
                m_body = 0; m_esc = 0; m_len = 0; m_cnt = 0;
            end
        end else if (b == 'hC1) begin
            e_v = 1; e_last = 1;
            e_stat = (m_esc ? 'h40 : 0) | (m_len ? 'h10 : 0);
            m_in = 0; m_esc = 0;
        end else if (!m_esc && b == 'h7D) begin
            m_esc = 1; m_body = 1;
        end else begin
            data = m_esc ? (b ^ 'h20) : b;
            m_esc = 0; m_body = 1;
            if (m_cnt >= int'(max_len)) m_len = 1;
            else begin m_cnt++; e_v = 1; e_byte = data; end
        end
    endtask

    task automatic send(bit v, int b);
        in_valid = v;
        in_byte  = 8'(b);
        @(posedge clk);
        model(v, b);
        @(negedge clk);
        compare_all();
    endtask

    task automatic put(int b);
        send(1'b1, b);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lfsr = 32'h1ACE5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R11";
        compare_all();
        send(0, 0);
        tag = "R1";
        check(tag, "sir_flags", int'(sir_flags), 'hC1C0);

        // garbage outside a frame
        tag = "R2";
        put('h11); put('hC1); put('h7D); put('h5E); put('hFF);

        // extra begin flags, plain payload, end flag
        tag = "R3";
        put('hC0); put('hC0); put('hC0);
        tag = "R4";
        put('h11); send(0, 0); put('h22); put('h33);
        tag = "R6";
        put('hC1); send(0, 0);
        check(tag, "final count", int'(rx_count), 3);

        // escapes
        tag = "R5";
        put('hC0); put('h7D); put('h5E); put('h7D); put('h5D);
        put('h7D); put('h7D); put('h7D); put('hE0); put('hC1);

        // cut short by a new begin flag
        tag = "R7";
        put('hC0); put('hAA); put('hC0); put('hBB); put('hC1);

        // length limit
        tag = "R8";
        max_len = 12'd3;
        put('hC0);
        for (int i = 0; i < 6; i++) put(i + 1);
        put('hC1);
        max_len = 12'd0;
        put('hC0); put('h55); put('hC1);
        put('hC0); put('hC1);
        max_len = 12'd2;
        put('hC0); put(1); put(2); put(3); put('hC0); put(4); put('hC1);

        // escape followed by a flag
        tag = "R9";
        max_len = 12'd100;
        put('hC0); put('h44); put('h7D); put('hC1);
        put('hC0); put('h7D); put('hC0); put('h45); put('hC1);

        // random, flag heavy
        tag = "R10";
        max_len = 12'd9;
        for (int i = 0; i < 6000; i++) begin
            int r, b;
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            r = lfsr & 'hFF;
            case (r % 12)
                0: b = 'hC0;
                1: b = 'hC1;
                2: b = 'h7D;
                default: b = (lfsr >> 8) & 'hFF;
            endcase
            if (i % 1500 == 0) max_len = 12'((i / 1500) * 3 + 1);
            send(((lfsr >> 20) & 3) != 0, b);
        end
        check("R10", "crc/over bits clear", int'(out_status & 8'h28), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule